// File: doc/BRIEF.md
# GPIO Input Qualification Filter

This block conditions asynchronous pin levels before other logic on the chip uses them. Every pin has a 2-bit mode. The mode selects one of four paths: a plain two-flop synchronizer, a synchronizer followed by a 3-sample agreement window, a synchronizer followed by a 6-sample agreement window, or a raw path with no flops.

Pins are grouped in blocks of eight. Each group has an 8-bit period field that sets how many system clocks lie between window samples. A free-running divider per group produces a sample strobe. Each windowed pin shifts its synchronized level into a short history on that strobe. The qualified output moves to a new level only when every sample in the selected window holds that level. While the samples disagree, the output keeps its previous value, so short glitches never reach the consumer.

Mode inputs pass through two register stages before they steer a pin. A new mode therefore applies on a fixed and known clock edge after it is presented.

Top module: `gpio_qual_filter`

## Requirements
- R1: While reset is high, every qualified output is 0, every pin's applied mode is 00, and every sample history holds all zeros.
- R2: Mode 00 (synchronize only) makes a pin's output equal to its raw input as it was two rising clock edges earlier.
- R3: Mode 11 (bypass) drives the output from the raw input combinationally, in the same cycle, with no register on the path.
- R4: Mode 01 selects a 3-sample window. With a group period of 0, a level change that stays stable appears at the output on the fifth rising edge after the pin changes.
- R5: Mode 10 selects a 6-sample window. With a group period of 0, a level change that stays stable appears at the output on the eighth rising edge after the pin changes.
- R6: In modes 01 and 10 the output keeps its last value whenever the samples in the window disagree. An input pulse shorter than the window never reaches the output.
- R7: Pin k belongs to group k/8, and group g reads its period from period bits [8g+7:8g]. A period of 0 takes a sample on every clock. A period of n (1..255) takes a sample every 2n clocks, from a free-running divider per group.
- R8: A mode value presented on the mode input takes control of its pin on the second rising edge after it is applied, and not before.
- R9: Because the history clears on reset, a pin held high in mode 10 across reset release reads 0 until eight rising edges after release, and reads 1 from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | N_PINS | Asynchronous pin levels |
| pin_mode | input | 2*N_PINS | Mode per pin; pin i at bits [2i+1:2i] |
| grp_period | input | 8*N_GROUPS | Sample period per group; group g at bits [8g+7:8g] |
| pin_qual | output | N_PINS | Qualified pin levels |

## Verification
The expected latencies, counted from a pin change, are:
- bypass: the same cycle;
- synchronize-only: two rising edges;
- 3-sample window at period 0: five edges;
- 6-sample window at period 0: eight edges;
- mode change: two edges after the new mode is applied.

The bench drives every input just after a falling edge and counts falling edges from there. Each falling edge marks exactly one rising edge that has passed, so every sample is taken one time unit after the edge count reaches the due cycle. For each latency the bench checks one edge before the due edge (old value) and the due edge itself (new value).

With nonzero periods, the divider phase is not known to the bench. For those cases the bench checks the earliest edge on which a change is still impossible, and the latest edge on which the change must already have happened.

// File: rtl/gpq_pkg.sv
package gpq_pkg;

    localparam int GRP_PINS = 8;
    localparam int PER_W    = 8;
    localparam int HIST_W   = 6;

    typedef enum logic [1:0] {
        QM_SYNC = 2'b00,
        QM_WIN3 = 2'b01,
        QM_WIN6 = 2'b10,
        QM_RAW  = 2'b11
    } qmode_e;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic              lvl;
    } win_state_t;

    // True when the newest 3 (or all 6) samples hold one value.
    function automatic logic win_agree(input logic [HIST_W-1:0] h, input logic wide);
        logic agree;
        if (wide) agree = (h == '0) || (h == '1);
        else      agree = (h[2:0] == 3'b000) || (h[2:0] == 3'b111);
        return agree;
    endfunction

endpackage

// File: rtl/gpq_sample_div.sv
module gpq_sample_div
    import gpq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    output logic             strobe
);
    localparam int CNT_W = PER_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit  = {period, 1'b0} - 1'b1;
        strobe = (period == '0) || (cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (strobe) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/gpq_sync2.sv
module gpq_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/gpq_window.sv
module gpq_window
    import gpq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe,
    input  qmode_e mode,
    input  logic   din,
    output logic   lvl
);
    win_state_t st;
    logic [HIST_W-1:0] next_hist;

    always_comb next_hist = {st.hist[HIST_W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (strobe) begin
            st.hist <= next_hist;
            if (win_agree(next_hist, mode == QM_WIN6))
                st.lvl <= next_hist[0];
        end
    end

    assign lvl = st.lvl;
endmodule

// File: rtl/gpio_qual_filter.sv
module gpio_qual_filter
    import gpq_pkg::*;
#(
    parameter int N_GROUPS = 2,
    localparam int N_PINS  = N_GROUPS * GRP_PINS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_PINS-1:0]         pin_raw,
    input  logic [2*N_PINS-1:0]       pin_mode,
    input  logic [PER_W*N_GROUPS-1:0] grp_period,
    output logic [N_PINS-1:0]         pin_qual
);
    logic [2*N_PINS-1:0] mode_d1;
    logic [2*N_PINS-1:0] mode_eff;
    logic [N_PINS-1:0]   sync_q;
    logic [N_PINS-1:0]   win_lvl;
    logic [N_GROUPS-1:0] grp_strobe;

    // Two-stage mode pipeline: a new mode steers the pin on the second edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_d1  <= '0;
            mode_eff <= '0;
        end else begin
            mode_d1  <= pin_mode;
            mode_eff <= mode_d1;
        end
    end

    gpq_sync2 #(.W(N_PINS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_raw),
        .dout (sync_q)
    );

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        gpq_sample_div u_div (
            .clk    (clk),
            .rst    (rst),
            .period (grp_period[PER_W*g +: PER_W]),
            .strobe (grp_strobe[g])
        );
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        gpq_window u_win (
            .clk    (clk),
            .rst    (rst),
            .strobe (grp_strobe[i / GRP_PINS]),
            .mode   (qmode_e'(mode_eff[2*i +: 2])),
            .din    (sync_q[i]),
            .lvl    (win_lvl[i])
        );
    end

    always_comb begin
        for (int i = 0; i < N_PINS; i++) begin
            case (qmode_e'(mode_eff[2*i +: 2]))
                QM_SYNC:          pin_qual[i] = sync_q[i];
                QM_WIN3, QM_WIN6: pin_qual[i] = win_lvl[i];
                QM_RAW:           pin_qual[i] = pin_raw[i];
                default:          pin_qual[i] = sync_q[i];
            endcase
        end
    end
endmodule

// File: rtl/gpq_checker.sv
module gpq_checker
    import gpq_pkg::*;
#(
    parameter int N_GROUPS = 2,
    localparam int N_PINS  = N_GROUPS * GRP_PINS
) (
    input logic                      clk,
    input logic                      rst,
    input logic [N_PINS-1:0]         pin_raw,
    input logic [2*N_PINS-1:0]       pin_mode,
    input logic [PER_W*N_GROUPS-1:0] grp_period,
    input logic [N_PINS-1:0]         pin_qual,
    input logic [2*N_PINS-1:0]       mode_eff,
    input logic [N_PINS-1:0]         sync_q,
    input logic [N_GROUPS-1:0]       grp_strobe
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_gchk
        // R7: with a nonzero period, two strobes never fall on adjacent cycles
        a_r7_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2) && $past(grp_strobe[g])
            && (grp_period[PER_W*g +: PER_W] != '0)
            && $stable(grp_period[PER_W*g +: PER_W])
            |-> !grp_strobe[g]);
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pchk
        localparam int G = i / GRP_PINS;

        // R8: the applied mode is the value presented two edges earlier
        a_r8_mode_delay: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2) |-> mode_eff[2*i +: 2] == $past(pin_mode[2*i +: 2], 2));

        // R2: synchronize-only mode reproduces the pin two edges late
        a_r2_sync_two: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2) && (mode_eff[2*i +: 2] == 2'b00)
            |-> pin_qual[i] == $past(pin_raw[i], 2));

        // R3: bypass mode is the raw pin in the same cycle
        a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
            (mode_eff[2*i +: 2] == 2'b11) |-> pin_qual[i] == pin_raw[i]);

        // R6: a windowed output moves only on the edge that follows a strobe
        a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2) && (mode_eff[2*i +: 2] inside {2'b01, 2'b10})
            && $stable(mode_eff[2*i +: 2]) && !$past(grp_strobe[G])
            |-> $stable(pin_qual[i]));

        // R4 / R5: a windowed change takes the value just sampled
        a_r5_change_agree: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2) && (mode_eff[2*i +: 2] inside {2'b01, 2'b10})
            && $stable(mode_eff[2*i +: 2]) && !$stable(pin_qual[i])
            |-> pin_qual[i] == $past(sync_q[i]));
    end
endmodule

bind gpio_qual_filter gpq_checker #(.N_GROUPS(N_GROUPS)) i_gpq_checker (
    .clk        (clk),
    .rst        (rst),
    .pin_raw    (pin_raw),
    .pin_mode   (pin_mode),
    .grp_period (grp_period),
    .pin_qual   (pin_qual),
    .mode_eff   (mode_eff),
    .sync_q     (sync_q),
    .grp_strobe (grp_strobe)
);

// File: tb/test_gpio_qual_filter.sv
module test_gpio_qual_filter;
    localparam int NG = 2;
    localparam int NP = NG * 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0]   pin_raw;
    logic [2*NP-1:0] pin_mode;
    logic [8*NG-1:0] grp_period;
    logic [NP-1:0]   pin_qual;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_qual_filter #(.N_GROUPS(NG)) i_gpio_qual_filter (
        .clk        (clk),
        .rst        (rst),
        .pin_raw    (pin_raw),
        .pin_mode   (pin_mode),
        .grp_period (grp_period),
        .pin_qual   (pin_qual)
    );

    // Each vector: mode[12:11], raw[10], edges[9:5], expected[4], req[3:0]
    localparam int NV = 16;
    localparam logic [12:0] VEC [NV] = '{
        {2'b00, 1'b1, 5'd1, 1'b0, 4'd2},  // R2 one edge: not yet
        {2'b00, 1'b1, 5'd1, 1'b1, 4'd2},  // R2 second edge
        {2'b00, 1'b0, 5'd2, 1'b0, 4'd2},  // R2 fall
        {2'b01, 1'b0, 5'd8, 1'b0, 4'd4},  // R4 settle
        {2'b01, 1'b1, 5'd4, 1'b0, 4'd4},  // R4 edge 4: not yet
        {2'b01, 1'b1, 5'd1, 1'b1, 4'd4},  // R4 edge 5
        {2'b01, 1'b0, 5'd2, 1'b1, 4'd6},  // R6 short low pulse
        {2'b01, 1'b1, 5'd8, 1'b1, 4'd6},  // R6 pulse rejected
        {2'b10, 1'b1, 5'd4, 1'b1, 4'd5},  // R5 switch to 6-sample
        {2'b10, 1'b0, 5'd7, 1'b1, 4'd5},  // R5 edge 7: not yet
        {2'b10, 1'b0, 5'd1, 1'b0, 4'd5},  // R5 edge 8
        {2'b10, 1'b1, 5'd4, 1'b0, 4'd6},  // R6 four-edge pulse
        {2'b10, 1'b0, 5'd8, 1'b0, 4'd6},  // R6 pulse rejected
        {2'b11, 1'b0, 5'd2, 1'b0, 4'd3},  // R3 enter bypass
        {2'b11, 1'b1, 5'd0, 1'b1, 4'd3},  // R3 same cycle rise
        {2'b11, 1'b0, 5'd0, 1'b0, 4'd3}   // R3 same cycle fall
    };

    task automatic chk(input logic [NP-1:0] act, input logic [NP-1:0] exp,
                       input int req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        pin_raw    = '1;
        pin_mode   = {NP{2'b10}};
        grp_period = '0;
        edges(4);
        chk(pin_qual, '0, 1, "outputs low in reset");            // R1
        rst = 1'b0;
        edges(7);
        chk(pin_qual, '0, 9, "high pins still low at edge 7");   // R9
        edges(1);
        chk(pin_qual, '1, 9, "high pins seen at edge 8");        // R9

        pin_mode = '0;
        pin_raw  = '0;
        edges(4);
        chk(pin_qual, '0, 2, "sync mode low after setup");       // R2

        for (int v = 0; v < NV; v++) begin
            pin_mode[1:0] = VEC[v][12:11];
            pin_raw[0]    = VEC[v][10];
            edges(int'(VEC[v][9:5]));
            chk({{(NP-1){1'b0}}, pin_qual[0]}, {{(NP-1){1'b0}}, VEC[v][4]},
                int'(VEC[v][3:0]), $sformatf("vector %0d", v));
        end

        // R8: leave 6-sample mode (output 1) for bypass with the pin low
        pin_mode[1:0] = 2'b10;
        pin_raw[0]    = 1'b1;
        edges(12);
        chk({15'd0, pin_qual[0]}, 16'd1, 5, "window high before mode switch");
        pin_mode[1:0] = 2'b11;
        pin_raw[0]    = 1'b0;
        edges(0);
        chk({15'd0, pin_qual[0]}, 16'd1, 8, "old mode at edge 0");
        edges(1);
        chk({15'd0, pin_qual[0]}, 16'd1, 8, "old mode at edge 1");
        edges(1);
        chk({15'd0, pin_qual[0]}, 16'd0, 8, "bypass at edge 2");

        // R7: pin 8 lives in group 1, group 1 period set to 1 then 4
        pin_mode[17:16]  = 2'b01;
        pin_raw[8]       = 1'b0;
        grp_period[15:8] = 8'd1;
        edges(20);
        chk({15'd0, pin_qual[8]}, 16'd0, 7, "group1 settled low");
        pin_raw[8] = 1'b1;
        edges(6);
        chk({15'd0, pin_qual[8]}, 16'd0, 7, "period 1: no change by edge 6");
        edges(2);
        chk({15'd0, pin_qual[8]}, 16'd1, 7, "period 1: changed by edge 8");
        grp_period[15:8] = 8'd4;
        edges(20);
        pin_raw[8] = 1'b0;
        edges(18);
        chk({15'd0, pin_qual[8]}, 16'd1, 7, "period 4: no change by edge 18");
        edges(8);
        chk({15'd0, pin_qual[8]}, 16'd0, 7, "period 4: changed by edge 26");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule